// File: doc/BRIEF.md
# Dedicated Input/Clock Pin Conditioning Cell

This cell sits behind an input-only pin of a programmable-logic fabric. It conditions the pin value before it enters the global routing matrix. A static capture mode picks one of four paths: a straight combinational pass, a single flop, a two-flop chain, or a level-sensitive latch. Every path other than the combinational one is timed by one of several global clocks, chosen by a static select field.

When the clock-source variant is built, the cell also sends the raw pin level through an inversion control onto a global clock net, where other cells can use it as a clock. The routed output always feeds the matrix, whichever mode is active. A synchronous reset, sampled on the selected clock, clears both flops of the chain.

Top module: `pin_clock_cell`

## Requirements
- R1: With capMode = 2'b00 (combinational), routeOut equals pinIn with no clock edge needed.
- R2: With capMode = 2'b01 (registered), after each rising edge of the selected clock routeOut holds the pinIn value sampled at that edge, and it holds that value until the next such edge.
- R3: With capMode = 2'b10 (double-registered), routeOut shows the pinIn value sampled two rising edges of the selected clock earlier.
- R4: With capMode = 2'b11 (latched), routeOut follows pinIn while the selected clock is high, and keeps the last value it followed while that clock is low.
- R5: clkSel (binary index into gClk) picks the only clock that times the cell; edges on the other gClk bits have no effect on routeOut.
- R6: rst high at a rising edge of the selected clock clears both flop stages to 0, so routeOut reads 0 in both the registered and the double-registered modes afterwards.
- R7: clkOut equals pinIn when clkInvert = 0 and the inverse of pinIn when clkInvert = 1, in every capture mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gClk | input | NUM_CLK | Global clocks available for capture |
| rst | input | 1 | Synchronous reset of the flop chain, active high |
| pinIn | input | 1 | Pin level after the pad |
| capMode | input | 2 | Static capture mode: 00 comb, 01 reg, 10 double reg, 11 latch |
| clkSel | input | SEL_W | Static index of the capture clock |
| clkInvert | input | 1 | Static inversion of the clock-source path |
| routeOut | output | 1 | Conditioned value into the routing matrix |
| clkOut | output | 1 | Pin driven onto a global clock net (0 if the path is not built) |

## Verification
The bench builds the cell with its default parameters: four global clocks and the clock-source path present. That lets every select value from 0 to 3 time the capture, while the other three clocks toggle as distractors, and both inversion settings be seen on clkOut. Each mode is driven with two-step pin sequences whose results tell a one-edge delay from a two-edge delay, and the latch is probed in both of its clock phases.

// File: rtl/pincell_pkg.sv
package pincell_pkg;
  typedef enum logic [1:0] {
    CAP_COMB  = 2'b00,
    CAP_REG   = 2'b01,
    CAP_DBL   = 2'b10,
    CAP_LATCH = 2'b11
  } capMode_e;

  // one strobe per output path, decoded by the control
  typedef struct packed {
    logic selComb;
    logic selReg;
    logic selDbl;
    logic selLatch;
  } capStrobe_t;
endpackage

// File: rtl/pincell_ctrl.sv
module pincell_ctrl
  import pincell_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic [NUM_CLK-1:0] gClk,
  input  logic [SEL_W-1:0]   clkSel,
  input  capMode_e           capMode,
  output logic               capClk,
  output capStrobe_t         strb
);
  // static select: pick the capture clock
  assign capClk = gClk[clkSel];

  always_comb begin
    strb = '0;
    unique case (capMode)
      CAP_COMB:  strb.selComb  = 1'b1;
      CAP_REG:   strb.selReg   = 1'b1;
      CAP_DBL:   strb.selDbl   = 1'b1;
      CAP_LATCH: strb.selLatch = 1'b1;
      default:   strb.selComb  = 1'b1;
    endcase
  end

  // R1 R2 R3 R4: exactly one output path is chosen
  always_comb begin
    strb_onehot_chk: assert ($onehot({strb.selComb, strb.selReg, strb.selDbl, strb.selLatch}) || $isunknown(capMode));
  end
endmodule

// File: rtl/pincell_dp.sv
module pincell_dp
  import pincell_pkg::*;
(
  input  logic       capClk,
  input  logic       rst,
  input  logic       pinIn,
  input  capStrobe_t strb,
  output logic       routeOut
);
  logic stage1Q;
  logic stage2Q;
  logic latchQ;

  always_ff @(posedge capClk) begin
    if (rst) begin
      stage1Q <= 1'b0;
      stage2Q <= 1'b0;
    end else begin
      stage1Q <= pinIn;
      stage2Q <= stage1Q;
    end
  end

  always_latch begin
    if (capClk) latchQ = pinIn;
  end

  always_comb begin
    routeOut = pinIn;
    if (strb.selReg)   routeOut = stage1Q;
    if (strb.selDbl)   routeOut = stage2Q;
    if (strb.selLatch) routeOut = latchQ;
  end

  // R2
  reg_follow_chk: assert property (@(posedge capClk) disable iff (rst)
    strb.selReg |=> (!strb.selReg || routeOut == $past(pinIn)));

  // R3
  dbl_chain_chk: assert property (@(posedge capClk) disable iff (rst)
    strb.selDbl |=> (!strb.selDbl || routeOut == $past(stage1Q)));

  // R4
  latch_open_chk: assert property (@(negedge capClk) disable iff (rst)
    strb.selLatch |-> routeOut == pinIn);

  // R6
  reset_clear_chk: assert property (@(posedge capClk)
    rst |=> (stage1Q == 1'b0 && stage2Q == 1'b0));
endmodule

// File: rtl/pin_clock_cell.sv
module pin_clock_cell
  import pincell_pkg::*;
#(
  parameter int NUM_CLK      = 4,
  parameter bit HAS_CLK_PATH = 1'b1,
  localparam int SEL_W       = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic [NUM_CLK-1:0] gClk,
  input  logic               rst,
  input  logic               pinIn,
  input  logic [1:0]         capMode,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic               clkInvert,
  output logic               routeOut,
  output logic               clkOut
);
  logic       capClk;
  capStrobe_t strb;

  pincell_ctrl #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) ctrl_i (
    .gClk    (gClk),
    .clkSel  (clkSel),
    .capMode (capMode_e'(capMode)),
    .capClk  (capClk),
    .strb    (strb)
  );

  pincell_dp dp_i (
    .capClk   (capClk),
    .rst      (rst),
    .pinIn    (pinIn),
    .strb     (strb),
    .routeOut (routeOut)
  );

  generate
    if (HAS_CLK_PATH) begin : g_clkSrc
      assign clkOut = pinIn ^ clkInvert;
    end else begin : g_noClkSrc
      assign clkOut = 1'b0;
    end
  endgenerate
endmodule

// File: tb/pin_clock_cell_tb.sv
module pin_clock_cell_tb_top;
  logic       tbClk = 1'b0;
  logic [3:0] gClk = '0;
  logic       rst = 1'b1;
  logic       pinIn = 1'b0;
  logic [1:0] capMode = 2'b01;
  logic [1:0] clkSel = 2'b00;
  logic       clkInvert = 1'b0;
  logic       routeOut;
  logic       clkOut;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 1'b0;

  always #2 tbClk = ~tbClk;   // 250 MHz

  pin_clock_cell dut_i (
    .gClk(gClk), .rst(rst), .pinIn(pinIn), .capMode(capMode),
    .clkSel(clkSel), .clkInvert(clkInvert), .routeOut(routeOut), .clkOut(clkOut)
  );

  // row: [7:6] mode, [5:4] sel, [3] invert, [2] first pin, [1] second pin, [0] expected routeOut
  localparam logic [7:0] VEC [10] = '{
    8'b00_00_0_011, 8'b01_00_0_100, 8'b01_01_1_011, 8'b01_11_0_111,
    8'b10_00_0_101, 8'b10_10_1_010, 8'b10_11_0_111, 8'b11_00_0_100,
    8'b11_10_1_011, 8'b00_01_1_100
  };

  task automatic pulse(input int idx);
    #2 gClk[idx] = 1'b1;
    #2 gClk[idx] = 1'b0;
    #2;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    // reset state (R6)
    #3 pulse(0);
    rst = 1'b0;
    #1 check("R6 reset reg", routeOut, 1'b0);
    capMode = 2'b10;
    #1 check("R6 reset dbl", routeOut, 1'b0);

    // vector table walk (R1 R2 R3 R4 R7)
    foreach (VEC[i]) begin
      capMode = VEC[i][7:6]; clkSel = VEC[i][5:4]; clkInvert = VEC[i][3];
      pinIn = VEC[i][2]; #1 pulse(int'(VEC[i][5:4]));
      pinIn = VEC[i][1]; #1 pulse(int'(VEC[i][5:4]));
      #1 check($sformatf("R1-mode%0d row%0d route", VEC[i][7:6], i), routeOut, VEC[i][0]);
      check("R7 table clkOut", clkOut, VEC[i][1] ^ VEC[i][3]);
    end

    // R1 comb follows with no edge
    capMode = 2'b00; pinIn = 1'b1; #1 check("R1 comb high", routeOut, 1'b1);
    pinIn = 1'b0; #1 check("R1 comb low", routeOut, 1'b0);

    // R5 other clocks ignored
    capMode = 2'b01; clkSel = 2'd1; pinIn = 1'b1; #1 pulse(1);
    check("R2 reg captures", routeOut, 1'b1);
    pinIn = 1'b0; #1 pulse(0); pulse(2); pulse(3);
    check("R5 other clocks ignored", routeOut, 1'b1);
    pulse(1);
    check("R5 selected clock captures", routeOut, 1'b0);

    // R3 one edge is not enough
    capMode = 2'b10; clkSel = 2'd3; pinIn = 1'b1; #1 pulse(3);
    check("R3 after one edge", routeOut, 1'b0);
    pinIn = 1'b0; #1 pulse(3);
    check("R3 after two edges", routeOut, 1'b1);

    // R4 latch phases
    capMode = 2'b11; clkSel = 2'd2; #1 gClk[2] = 1'b1;
    pinIn = 1'b1; #1 check("R4 open follows 1", routeOut, 1'b1);
    pinIn = 1'b0; #1 check("R4 open follows 0", routeOut, 1'b0);
    pinIn = 1'b1; #1 gClk[2] = 1'b0;
    #1 pinIn = 1'b0; #1 check("R4 closed holds", routeOut, 1'b1);

    // R6 reset mid-run
    capMode = 2'b10; clkSel = 2'd0; pinIn = 1'b1; #1 pulse(0); pulse(0);
    check("R6 before reset", routeOut, 1'b1);
    rst = 1'b1; #1 pulse(0); rst = 1'b0;
    #1 check("R6 dbl cleared", routeOut, 1'b0);
    capMode = 2'b01; #1 check("R6 reg cleared", routeOut, 1'b0);

    // R7 all combinations
    for (int k = 0; k < 4; k++) begin
      clkInvert = k[1]; pinIn = k[0];
      #1 check("R7 clkOut", clkOut, k[0] ^ k[1]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule